// File: doc/BRIEF.md
# Reboot Command Word Sequencer

This block turns a single trigger pulse into the fixed series of 16-bit command words that makes a device configuration engine restart from a chosen image. The series starts with a padding word and two synchronisation words. It then writes four registers: the low and high halves of the next-image address, and the low and high halves of the golden (fallback) address. A command-register write follows, then the reboot command itself, and a final no-op word closes the series.

The caller presents a 24-bit next-image address, a 24-bit golden address and an 8-bit memory read opcode, then pulses the trigger. All three values are sampled in that cycle and held internally for the whole series. Typical opcodes are 0x0B (single fast read), 0x3B (dual) and 0x6B (quad). The block does not check the opcode.

Words leave on a valid/ready stream. `cmd_valid_o` stays high while a word is on offer. The sink may hold `cmd_ready_i` low for any number of cycles. During that time the word on `cmd_word_o` does not change and nothing is lost. One word is consumed on each rising edge where both valid and ready are high. `busy_o` is a plain status pin that covers the whole series.

Top module: `reboot_seq`

## Requirements
- R1: After reset, `busy_o` and `cmd_valid_o` are low.
- R2: A trigger while idle sets `busy_o` and `cmd_valid_o` on the next cycle, and `cmd_word_o` is then 0xFFFF.
- R3: Exactly 14 words are accepted per series, in this order: 0xFFFF, 0xAA99, 0x5566, 0x3261, NEXT[15:0], 0x3281, NEXT-HIGH, 0x32A1, GOLD[15:0], 0x32C1, GOLD-HIGH, 0x30A1, 0x000E, 0x2000.
- R4: In each high-address word (the 7th and 11th words of the series), bits [15:8] hold the read opcode and bits [7:0] hold bits [23:16] of the corresponding address. The low-address words hold address bits [15:0] unchanged.
- R5: The series advances only on a cycle with both `cmd_valid_o` and `cmd_ready_i` high. While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_word_o` and `cmd_valid_o` do not change.
- R6: The addresses and the opcode are sampled in the trigger cycle. Later changes to those inputs do not alter the words of the running series.
- R7: A trigger while `busy_o` is high is ignored, and the running series continues unchanged.
- R8: `busy_o` and `cmd_valid_o` go low in the cycle after the last word (0x2000) is accepted. A trigger in that idle cycle starts a fresh series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Trigger pulse; acted on only while idle |
| next_addr_i | input | 24 | Start address of the image to boot next |
| gold_addr_i | input | 24 | Start address of the fallback image |
| rd_opcode_i | input | 8 | Memory read opcode packed into the high-address words |
| cmd_word_o | output | 16 | Current command word |
| cmd_valid_o | output | 1 | A word is on offer |
| cmd_ready_i | input | 1 | Sink accepts the word this cycle |
| busy_o | output | 1 | A series is in progress |

## Verification
A wrong word index appears on `cmd_word_o` at the very next handshake, as a swapped, repeated or skipped constant. A fault in the captured fields shows only at the 5th, 7th, 9th or 11th word, so address patterns with distinct high bytes, all-ones and all-zeros are used to expose packing errors. A misplaced end of series appears as `busy_o` staying high past 0x2000, or falling early, on the cycle right after the final acceptance. Long stalls and triggers issued mid-series show whether the word is held under back-pressure and whether an ignored trigger leaks through.

// File: rtl/reboot_seq_pkg.sv
package reboot_seq_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 24;
  localparam int OP_W      = 8;
  localparam int NUM_WORDS = 14;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int HI_W      = ADDR_W - WORD_W;

  typedef enum logic [2:0] {
    SRC_CONST   = 3'd0,
    SRC_NEXT_LO = 3'd1,
    SRC_NEXT_HI = 3'd2,
    SRC_GOLD_LO = 3'd3,
    SRC_GOLD_HI = 3'd4
  } slot_src_e;

  typedef struct packed {
    slot_src_e         src;
    logic [WORD_W-1:0] k;
  } slot_t;

  // Per-position word source; the order is the protocol itself.
  function automatic slot_t slot_of(input logic [IDX_W-1:0] idx);
    slot_t s;
    s.src = SRC_CONST;
    s.k   = '0;
    case (idx)
      4'd0:    s.k = 16'hFFFF;
      4'd1:    s.k = 16'hAA99;
      4'd2:    s.k = 16'h5566;
      4'd3:    s.k = 16'h3261;
      4'd4:    s.src = SRC_NEXT_LO;
      4'd5:    s.k = 16'h3281;
      4'd6:    s.src = SRC_NEXT_HI;
      4'd7:    s.k = 16'h32A1;
      4'd8:    s.src = SRC_GOLD_LO;
      4'd9:    s.k = 16'h32C1;
      4'd10:   s.src = SRC_GOLD_HI;
      4'd11:   s.k = 16'h30A1;
      4'd12:   s.k = 16'h000E;
      default: s.k = 16'h2000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/reboot_seq_ctrl.sv
module reboot_seq_ctrl
  import reboot_seq_pkg::*;
#(
  parameter int N_WORDS = NUM_WORDS,
  localparam int IW     = $clog2(N_WORDS),
  localparam logic [IW-1:0] LAST = IW'(N_WORDS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic          busy,
  output logic          load,
  output logic [IW-1:0] idx
);
  assign load = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && ready) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/reboot_seq_hold.sv
module reboot_seq_hold #(
  parameter int AW = 24,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] next_in,
  input  logic [AW-1:0] gold_in,
  input  logic [OW-1:0] op_in,
  output logic [AW-1:0] next_q,
  output logic [AW-1:0] gold_q,
  output logic [OW-1:0] op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      gold_q <= '0;
      op_q   <= '0;
    end else if (load) begin
      next_q <= next_in;
      gold_q <= gold_in;
      op_q   <= op_in;
    end
  end
endmodule

// File: rtl/reboot_seq_mux.sv
module reboot_seq_mux
  import reboot_seq_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] next_q,
  input  logic [ADDR_W-1:0] gold_q,
  input  logic [OP_W-1:0]   op_q,
  output logic [WORD_W-1:0] word
);
  slot_t s;

  always_comb begin
    s = slot_of(idx);
    unique case (s.src)
      SRC_NEXT_LO: word = next_q[WORD_W-1:0];
      SRC_NEXT_HI: word = {op_q, next_q[ADDR_W-1:WORD_W]};
      SRC_GOLD_LO: word = gold_q[WORD_W-1:0];
      SRC_GOLD_HI: word = {op_q, gold_q[ADDR_W-1:WORD_W]};
      default:     word = s.k;
    endcase
  end
endmodule

// File: rtl/reboot_seq.sv
module reboot_seq
  import reboot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic [ADDR_W-1:0] gold_addr_i,
  input  logic [OP_W-1:0]   rd_opcode_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              busy_o
);
  logic             busy, load;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] next_q, gold_q;
  logic [OP_W-1:0]   op_q;

  reboot_seq_ctrl #(.N_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .ready(cmd_ready_i),
    .busy(busy), .load(load), .idx(idx)
  );

  reboot_seq_hold #(.AW(ADDR_W), .OW(OP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load),
    .next_in(next_addr_i), .gold_in(gold_addr_i), .op_in(rd_opcode_i),
    .next_q(next_q), .gold_q(gold_q), .op_q(op_q)
  );

  reboot_seq_mux u_mux (
    .idx(idx), .next_q(next_q), .gold_q(gold_q), .op_q(op_q), .word(cmd_word_o)
  );

  assign cmd_valid_o = busy;
  assign busy_o      = busy;
endmodule

// File: rtl/reboot_seq_chk.sv
module reboot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [23:0] next_addr_i,
  input logic [23:0] gold_addr_i,
  input logic [7:0]  rd_opcode_i,
  input logic [15:0] cmd_word_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic        busy_o
);
  logic [4:0]  cnt;
  logic [23:0] c_next, c_gold;
  logic [7:0]  c_op;
  logic        hs;

  assign hs = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; c_next <= '0; c_gold <= '0; c_op <= '0;
    end else if (!busy_o) begin
      cnt <= '0;
      if (start_i) begin
        c_next <= next_addr_i; c_gold <= gold_addr_i; c_op <= rd_opcode_i;
      end
    end else if (hs) begin
      cnt <= cnt + 5'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy_o && !cmd_valid_o);

  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o && cmd_valid_o && cmd_word_o == 16'hFFFF);

  p_sync_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cnt == 5'd1 |-> cmd_word_o == 16'hAA99);

  p_cmd_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cnt == 5'd12 |-> cmd_word_o == 16'h000E);

  p_next_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cnt == 5'd6 |-> cmd_word_o == {c_op, c_next[23:16]});

  p_gold_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cnt == 5'd10 |-> cmd_word_o == {c_op, c_gold[23:16]});

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_word_o));

  p_gold_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && cnt == 5'd8 |-> cmd_word_o == c_gold[15:0]);

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(hs && cnt == 5'd13) |=> busy_o);

  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && hs && cnt == 5'd13 |=> !busy_o && !cmd_valid_o);
endmodule

bind reboot_seq reboot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_addr_i(next_addr_i),
  .gold_addr_i(gold_addr_i), .rd_opcode_i(rd_opcode_i), .cmd_word_o(cmd_word_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .busy_o(busy_o)
);

// File: tb/reboot_seq_tb_top.sv
module reboot_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] next_addr_i = '0;
  logic [23:0] gold_addr_i = '0;
  logic [7:0]  rd_opcode_i = '0;
  logic        cmd_ready_i = 1'b1;
  logic [15:0] cmd_word_o;
  logic        cmd_valid_o, busy_o;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  string cur_req = "R3";

  logic [15:0] exp_q[$];
  logic [15:0] acc_q[$];
  logic        m_busy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reboot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_addr_i(next_addr_i),
    .gold_addr_i(gold_addr_i), .rd_opcode_i(rd_opcode_i), .cmd_word_o(cmd_word_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of expected words built at the trigger.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      exp_q.delete();
    end else if (m_busy) begin
      if (cmd_ready_i) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) m_busy = 1'b0;
      end
    end else if (start_i) begin
      exp_q = '{16'hFFFF, 16'hAA99, 16'h5566,
                16'h3261, next_addr_i[15:0],
                16'h3281, {rd_opcode_i, next_addr_i[23:16]},
                16'h32A1, gold_addr_i[15:0],
                16'h32C1, {rd_opcode_i, gold_addr_i[23:16]},
                16'h30A1, 16'h000E, 16'h2000};
      m_busy = 1'b1;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " busy"}, {31'd0, busy_o}, {31'd0, m_busy});
      check({cur_req, " valid"}, {31'd0, cmd_valid_o}, {31'd0, m_busy});
      if (m_busy) check({cur_req, " word"}, {16'd0, cmd_word_o}, {16'd0, exp_q[0]});
      if (cmd_valid_o && cmd_ready_i) acc_q.push_back(cmd_word_o);
    end
  end

  // Ready driver: 0 always ready, 1 random, 2 long stalls.
  int stall_ctr = 0;
  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: cmd_ready_i = 1'b1;
      1: cmd_ready_i = $urandom_range(0, 1) == 1;
      default: begin
        stall_ctr++;
        cmd_ready_i = (stall_ctr % 5) == 0;
      end
    endcase
  end

  task automatic trigger(input logic [23:0] na, input logic [23:0] ga, input logic [7:0] op);
    @(posedge clk); #2;
    next_addr_i = na; gold_addr_i = ga; rd_opcode_i = op; start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy at reset", {31'd0, busy_o}, 32'd0);
    check("R1 valid at reset", {31'd0, cmd_valid_o}, 32'd0);
    @(posedge clk); #2; rst_n = 1'b1;

    // Stream A: always ready, single fast read
    cur_req = "R2/R3";
    acc_q.delete();
    trigger(24'h123456, 24'hABCDEF, 8'h0B);
    @(negedge clk);
    wait_idle();
    check("R3 word count", acc_q.size(), 32'd14);
    check("R2 first word", {16'd0, acc_q[0]}, 32'h0000FFFF);
    check("R4 next low", {16'd0, acc_q[4]}, 32'h00003456);
    check("R4 next high", {16'd0, acc_q[6]}, 32'h00000B12);
    check("R4 gold high", {16'd0, acc_q[10]}, 32'h00000BAB);
    check("R3 last word", {16'd0, acc_q[13]}, 32'h00002000);
    check("R8 idle after last", {31'd0, busy_o}, 32'd0);

    // Stream B: random back-pressure, inputs disturbed, retrigger mid-series
    cur_req = "R5/R6/R7";
    ready_mode = 1;
    acc_q.delete();
    trigger(24'h5A0F33, 24'h01C3E7, 8'h3B);
    next_addr_i = 24'hFFFFFF; gold_addr_i = 24'h000000; rd_opcode_i = 8'h6B;
    repeat (4) @(posedge clk);
    #2; start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    wait_idle();
    check("R6 next high kept", {16'd0, acc_q[6]}, 32'h00003B5A);
    check("R7 series length", acc_q.size(), 32'd14);

    // Stream C: long stalls, extreme addresses, back-to-back restart
    cur_req = "R5/R8";
    ready_mode = 2;
    acc_q.delete();
    trigger(24'hFFFFFF, 24'h000000, 8'h6B);
    wait_idle();
    check("R4 gold all-zero high", {16'd0, acc_q[10]}, 32'h00006B00);
    check("R4 next all-ones low", {16'd0, acc_q[4]}, 32'h0000FFFF);
    ready_mode = 0;
    cur_req = "R8";
    acc_q.delete();
    #2; start_i = 1'b1;
    next_addr_i = 24'h00ABCD; gold_addr_i = 24'h7F0001; rd_opcode_i = 8'h0B;
    @(posedge clk); #2; start_i = 1'b0;
    wait_idle();
    check("R8 restart count", acc_q.size(), 32'd14);
    check("R8 restart gold low", {16'd0, acc_q[8]}, 32'h00000001);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule